// File: doc/BRIEF.md
# Pipelined Floating-Point Adder/Subtractor

This block adds two floating-point numbers in a sign / biased exponent / fraction format whose field widths are parameters. Each operand word has the sign in its top bit, then an `EXP_W`-bit exponent, then an `FRAC_W`-bit fraction in the low bits. A nonzero exponent stands for a normal number with a hidden leading one. The exponent bias is 2^(EXP_W-1)-1, which is 127 for the default 1/8/23 layout. An exponent field of zero means the value is zero, whatever its fraction holds. Subtraction is done by passing an operand with its sign bit inverted. Results are truncated toward zero at every step. There is no rounding, no denormal support and no special handling of NaN payloads.

A caller presents both operands together with a one-cycle `ready` strobe and an `exc_in` flag. The work passes through four registered steps. The first orders the operands by magnitude. The second aligns the smaller mantissa to the larger exponent. The third adds or subtracts the mantissas. The fourth normalises the sum and packs the result. A one-cycle `done` strobe marks the result. A new operand pair may be accepted on every cycle, so several additions can be in flight at once. `exc_out` reports the incoming flag together with any exponent overflow.

Top module: `fp_add_pipe`

## Requirements
- R1: Swapping the two operands gives the same result word and the same exception flag. The result sign is the sign of the operand with the larger magnitude.
- R2: The smaller mantissa (hidden one included) is shifted right by the exponent difference, and the bits shifted out are discarded. With default widths, 1.0 (3F800000) plus 1.5·2^-23 (34400000) gives 3F800001. A difference of 24 or more contributes nothing: 2.0 (40000000) plus 34400000 gives 40000000.
- R3: Operands with equal signs add. When the mantissa sum carries out, the mantissa shifts right by one and the exponent rises by one: 3.0 + 3.0 gives 40C00000.
- R4: Operands with different signs subtract the smaller magnitude from the larger. Leading zeros are then removed by shifting left and lowering the exponent: 1.0 + (-1.5) gives BF000000.
- R5: Equal magnitudes with opposite signs give an all-zero word (+0).
- R6: An operand whose exponent field is zero counts as zero, even when its fraction bits are not zero.
- R7: If the corrected exponent reaches all ones, `exc_out` is 1 and the result is infinity of the result sign (exponent all ones, fraction zero). For example, 7F7FFFFF + 7F7FFFFF gives 7F800000 with `exc_out`=1.
- R8: `exc_in` travels with its operands and appears on `exc_out` together with their result.
- R9: If normalisation would bring the exponent below 1, the result is +0 (all zeros) and no exception is raised.
- R10: Operands sampled with `ready`=1 at clock edge n give `done`=1 for exactly the one cycle after edge n+3. Each `ready` yields one `done`, and `ready` may be high on consecutive cycles.
- R11: Reset clears `result`, `done` and `exc_out` to 0. Between `done` pulses, `result` and `exc_out` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ready | input | 1 | Operand pair valid this cycle |
| op_a | input | 1+EXP_W+FRAC_W | First operand |
| op_b | input | 1+EXP_W+FRAC_W | Second operand |
| exc_in | input | 1 | Exception flag carried with the operands |
| result | output | 1+EXP_W+FRAC_W | Sum, held until the next done |
| done | output | 1 | One-cycle strobe marking a new result |
| exc_out | output | 1 | exc_in or exponent overflow for this result |

## Verification
Two situations are hard to reach from the ports. One is the fourth step's two boundaries: exponent overflow after a carry, and exponent underflow after a long left shift. Sums such as the largest finite value added to itself, or two nearly equal numbers at the smallest normal exponent, land exactly on these boundaries. The other is the swap's tie-break and the alignment truncation. Mirrored operand pairs and small addends whose exponent gap is 23 or 24 show whether bits below the mantissa are dropped rather than rounded. Back-to-back `ready` strobes show that results in flight stay separate.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
    localparam int DEF_EXP_W  = 8;
    localparam int DEF_FRAC_W = 23;
    // register stages from the ready edge to done
    localparam int PIPE_DEPTH = 4;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } mant_op_e;
endpackage

// File: rtl/fpa_swap.sv
module fpa_swap #(
    parameter int EXP_W  = fpa_pkg::DEF_EXP_W,
    parameter int FRAC_W = fpa_pkg::DEF_FRAC_W,
    localparam int N = 1 + EXP_W + FRAC_W,
    localparam int M = FRAC_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [N-1:0]     a,
    input  logic [N-1:0]     b,
    input  logic             in_exc,
    output logic             out_vld,
    output logic             out_exc,
    output logic             big_sign,
    output logic [EXP_W-1:0] big_exp,
    output logic [M-1:0]     big_man,
    output logic             sml_sign,
    output logic [EXP_W-1:0] sml_exp,
    output logic [M-1:0]     sml_man
);
    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [M-1:0]     man;
    } unpacked_t;

    function automatic unpacked_t split(input logic [N-1:0] w);
        unpacked_t u;
        u.sign = w[N-1];
        u.exp  = w[N-2 -: EXP_W];
        u.man  = (u.exp == '0) ? '0 : {1'b1, w[FRAC_W-1:0]};
        if (u.exp == '0) u.sign = 1'b0;
        return u;
    endfunction

    unpacked_t ua, ub, hi, lo;
    logic a_ge_b;

    always_comb begin
        ua     = split(a);
        ub     = split(b);
        a_ge_b = {ua.exp, ua.man} >= {ub.exp, ub.man};
        hi     = a_ge_b ? ua : ub;
        lo     = a_ge_b ? ub : ua;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= 1'b0;
            out_exc  <= 1'b0;
            big_sign <= 1'b0;
            big_exp  <= '0;
            big_man  <= '0;
            sml_sign <= 1'b0;
            sml_exp  <= '0;
            sml_man  <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_exc  <= in_exc;
                big_sign <= hi.sign;
                big_exp  <= hi.exp;
                big_man  <= hi.man;
                sml_sign <= lo.sign;
                sml_exp  <= lo.exp;
                sml_man  <= lo.man;
            end
        end
    end

    AST_SWAP_ORDER: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> ({big_exp, big_man} >= {sml_exp, sml_man})); // R1
endmodule

// File: rtl/fpa_align.sv
module fpa_align #(
    parameter int EXP_W  = fpa_pkg::DEF_EXP_W,
    parameter int FRAC_W = fpa_pkg::DEF_FRAC_W,
    localparam int M = FRAC_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_vld,
    input  logic               in_exc,
    input  logic               big_sign,
    input  logic [EXP_W-1:0]   big_exp,
    input  logic [M-1:0]       big_man,
    input  logic               sml_sign,
    input  logic [EXP_W-1:0]   sml_exp,
    input  logic [M-1:0]       sml_man,
    output logic               out_vld,
    output logic               out_exc,
    output fpa_pkg::mant_op_e  out_op,
    output logic               out_sign,
    output logic [EXP_W-1:0]   out_exp,
    output logic [M-1:0]       out_man_b,
    output logic [M-1:0]       out_man_s
);
    import fpa_pkg::*;

    logic [EXP_W-1:0] gap;
    logic [M-1:0]     shifted;

    always_comb begin
        gap     = big_exp - sml_exp;
        shifted = (32'(gap) >= M) ? '0 : (sml_man >> gap);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld   <= 1'b0;
            out_exc   <= 1'b0;
            out_op    <= OP_ADD;
            out_sign  <= 1'b0;
            out_exp   <= '0;
            out_man_b <= '0;
            out_man_s <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_exc   <= in_exc;
                out_op    <= (big_sign != sml_sign) ? OP_SUB : OP_ADD;
                out_sign  <= big_sign;
                out_exp   <= big_exp;
                out_man_b <= big_man;
                out_man_s <= shifted;
            end
        end
    end

    AST_ALIGN_NOT_LARGER: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (out_man_s <= out_man_b)); // R2
endmodule

// File: rtl/fpa_addsub.sv
module fpa_addsub #(
    parameter int EXP_W  = fpa_pkg::DEF_EXP_W,
    parameter int FRAC_W = fpa_pkg::DEF_FRAC_W,
    localparam int M = FRAC_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic              in_exc,
    input  fpa_pkg::mant_op_e in_op,
    input  logic              in_sign,
    input  logic [EXP_W-1:0]  in_exp,
    input  logic [M-1:0]      man_b,
    input  logic [M-1:0]      man_s,
    output logic              out_vld,
    output logic              out_exc,
    output logic              out_sub,
    output logic              out_sign,
    output logic [EXP_W-1:0]  out_exp,
    output logic [M:0]        out_sum
);
    import fpa_pkg::*;

    logic [M:0] raw;

    always_comb begin
        if (in_op == OP_SUB) raw = {1'b0, man_b} - {1'b0, man_s};
        else                 raw = {1'b0, man_b} + {1'b0, man_s};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= 1'b0;
            out_exc  <= 1'b0;
            out_sub  <= 1'b0;
            out_sign <= 1'b0;
            out_exp  <= '0;
            out_sum  <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_exc  <= in_exc;
                out_sub  <= (in_op == OP_SUB);
                out_sign <= in_sign;
                out_exp  <= in_exp;
                out_sum  <= raw;
            end
        end
    end

    AST_SUB_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
        (out_vld && out_sub) |-> !out_sum[M]); // R4
endmodule

// File: rtl/fpa_correct.sv
module fpa_correct #(
    parameter int EXP_W  = fpa_pkg::DEF_EXP_W,
    parameter int FRAC_W = fpa_pkg::DEF_FRAC_W,
    localparam int N   = 1 + EXP_W + FRAC_W,
    localparam int M   = FRAC_W + 1,
    localparam int LZW = $clog2(M + 1),
    localparam int EW1 = EXP_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic             in_exc,
    input  logic             in_sign,
    input  logic [EXP_W-1:0] in_exp,
    input  logic [M:0]       in_sum,
    output logic             done_o,
    output logic [N-1:0]     result_o,
    output logic             exc_o
);
    function automatic logic [LZW-1:0] lead_zeros(input logic [M-1:0] v);
        logic [LZW-1:0] n;
        n = LZW'(M);
        for (int i = 0; i < M; i++) begin
            if (v[i]) n = LZW'(M - 1 - i);
        end
        return n;
    endfunction

    logic [LZW-1:0]   lz;
    logic [EW1-1:0]   exp_up;
    logic [M-1:0]     man_n;
    logic [EXP_W-1:0] exp_n;
    logic             ovf, zero_res;
    logic [N-1:0]     packed_res;

    always_comb begin
        lz       = lead_zeros(in_sum[M-1:0]);
        exp_up   = EW1'(in_exp) + EW1'(1);
        ovf      = 1'b0;
        zero_res = 1'b0;
        man_n    = in_sum[M-1:0];
        exp_n    = in_exp;
        if (in_sum == '0) begin
            zero_res = 1'b1;
        end else if (in_sum[M]) begin
            man_n = in_sum[M:1];
            exp_n = exp_up[EXP_W-1:0];
            ovf   = (exp_up >= EW1'({EXP_W{1'b1}}));
        end else if (EW1'(in_exp) <= EW1'(lz)) begin
            zero_res = 1'b1;
        end else begin
            man_n = in_sum[M-1:0] << lz;
            exp_n = in_exp - EXP_W'(lz);
        end
        if (zero_res)
            packed_res = '0;
        else if (ovf)
            packed_res = {in_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else
            packed_res = {in_sign, exp_n, man_n[FRAC_W-1:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o   <= 1'b0;
            result_o <= '0;
            exc_o    <= 1'b0;
        end else begin
            done_o <= in_vld;
            if (in_vld) begin
                result_o <= packed_res;
                exc_o    <= in_exc | ovf;
            end
        end
    end

    AST_ZERO_IS_POSITIVE: assert property (@(posedge clk) disable iff (rst)
        (done_o && result_o[N-2:0] == '0) |-> !result_o[N-1]); // R5
    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(result_o) && $stable(exc_o))); // R11
endmodule

// File: rtl/fp_add_pipe.sv
module fp_add_pipe #(
    parameter int EXP_W  = fpa_pkg::DEF_EXP_W,
    parameter int FRAC_W = fpa_pkg::DEF_FRAC_W,
    localparam int N = 1 + EXP_W + FRAC_W,
    localparam int M = FRAC_W + 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ready,
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    input  logic         exc_in,
    output logic [N-1:0] result,
    output logic         done,
    output logic         exc_out
);
    import fpa_pkg::*;

    logic             v1, x1, bs1, ss1;
    logic [EXP_W-1:0] be1, se1;
    logic [M-1:0]     bm1, sm1;

    logic             v2, x2, s2;
    mant_op_e         op2;
    logic [EXP_W-1:0] e2;
    logic [M-1:0]     mb2, ms2;

    logic             v3, x3, sub3, s3;
    logic [EXP_W-1:0] e3;
    logic [M:0]       sum3;

    fpa_swap #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_swap (
        .clk(clk), .rst(rst), .in_vld(ready), .a(op_a), .b(op_b), .in_exc(exc_in),
        .out_vld(v1), .out_exc(x1),
        .big_sign(bs1), .big_exp(be1), .big_man(bm1),
        .sml_sign(ss1), .sml_exp(se1), .sml_man(sm1)
    );

    fpa_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
        .clk(clk), .rst(rst), .in_vld(v1), .in_exc(x1),
        .big_sign(bs1), .big_exp(be1), .big_man(bm1),
        .sml_sign(ss1), .sml_exp(se1), .sml_man(sm1),
        .out_vld(v2), .out_exc(x2), .out_op(op2), .out_sign(s2),
        .out_exp(e2), .out_man_b(mb2), .out_man_s(ms2)
    );

    fpa_addsub #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_addsub (
        .clk(clk), .rst(rst), .in_vld(v2), .in_exc(x2), .in_op(op2),
        .in_sign(s2), .in_exp(e2), .man_b(mb2), .man_s(ms2),
        .out_vld(v3), .out_exc(x3), .out_sub(sub3), .out_sign(s3),
        .out_exp(e3), .out_sum(sum3)
    );

    fpa_correct #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_correct (
        .clk(clk), .rst(rst), .in_vld(v3), .in_exc(x3), .in_sign(s3),
        .in_exp(e3), .in_sum(sum3),
        .done_o(done), .result_o(result), .exc_o(exc_out)
    );

    AST_DONE_FROM_PIPE: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(v3)); // R10
    AST_EXC_CARRIED: assert property (@(posedge clk) disable iff (rst)
        (done && $past(x3)) |-> exc_out); // R8
endmodule

// File: tb/sim_fp_add_pipe.sv
`timescale 1ns/1ps
module sim_fp_add_pipe;
    localparam int NV = 19;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ready = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        exc_in = 1'b0;
    logic [31:0] result;
    logic        done, exc_out;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    fp_add_pipe u0 (
        .clk(clk), .rst(rst), .ready(ready), .op_a(op_a), .op_b(op_b),
        .exc_in(exc_in), .result(result), .done(done), .exc_out(exc_out)
    );

    localparam logic [31:0] VA [NV] = '{
        32'h3F800000, 32'h40000000, 32'h3F800000, 32'h40400000, 32'h40400000,
        32'hBF800000, 32'h3F800000, 32'hBFC00000, 32'h3F800000, 32'h00000000,
        32'h007FFFFF, 32'h3F800000, 32'h40000000, 32'h3F800000, 32'h7F7FFFFF,
        32'hFF7FFFFF, 32'h00C00000, 32'h3F800000, 32'h00000000};
    localparam logic [31:0] VB [NV] = '{
        32'h40000000, 32'h3F800000, 32'h3F800000, 32'h40400000, 32'hBF800000,
        32'h40800000, 32'hBFC00000, 32'h3F800000, 32'hBF800000, 32'h40400000,
        32'h3F800000, 32'h34400000, 32'h34400000, 32'h30800000, 32'h7F7FFFFF,
        32'hFF7FFFFF, 32'h80800000, 32'h40000000, 32'h00000000};
    localparam logic VX [NV] = '{
        1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
        1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
    localparam logic [31:0] VR [NV] = '{
        32'h40400000, 32'h40400000, 32'h40000000, 32'h40C00000, 32'h40000000,
        32'h40400000, 32'hBF000000, 32'hBF000000, 32'h00000000, 32'h40400000,
        32'h3F800000, 32'h3F800001, 32'h40000000, 32'h3F800000, 32'h7F800000,
        32'hFF800000, 32'h00000000, 32'h40400000, 32'h00000000};
    localparam logic VE [NV] = '{
        1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
        1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};

    function automatic string tag_of(input int i);
        case (i)
            1, 7:         return "R1";
            11, 12, 13:   return "R2";
            0, 2, 3:      return "R3";
            4, 5, 6:      return "R4";
            8:            return "R5";
            9, 10, 18:    return "R6";
            14, 15:       return "R7";
            16:           return "R9";
            17:           return "R8";
            default:      return "R?";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // drive at negedge, ready sampled at the next posedge, done after 4 edges
    task automatic run_one(input int i);
        @(negedge clk);
        op_a = VA[i]; op_b = VB[i]; exc_in = VX[i]; ready = 1'b1;
        @(posedge clk); #1;
        ready = 1'b0; exc_in = 1'b0;
        repeat (fpa_pkg::PIPE_DEPTH - 1) @(posedge clk);
        @(negedge clk);
        check("R10", "done at latency", 32'(done), 32'd1);
        check(tag_of(i), "result", result, VR[i]);
        check(tag_of(i), "exc_out", 32'(exc_out), 32'(VE[i]));
        @(negedge clk);
        check("R10", "done single pulse", 32'(done), 32'd0);
        check("R11", "result held", result, VR[i]);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R11", "reset result", result, 32'h0);
        check("R11", "reset done", 32'(done), 32'd0);
        check("R11", "reset exc_out", 32'(exc_out), 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) run_one(i);

        // R10: back-to-back operands give two consecutive done pulses
        @(negedge clk);
        op_a = VA[0]; op_b = VB[0]; ready = 1'b1;
        @(negedge clk);
        op_a = VA[14]; op_b = VB[14];
        @(negedge clk);
        ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R10", "b2b first done", 32'(done), 32'd1);
        check("R10", "b2b first result", result, VR[0]);
        check("R10", "b2b first exc", 32'(exc_out), 32'd0);
        @(negedge clk);
        check("R10", "b2b second done", 32'(done), 32'd1);
        check("R10", "b2b second result", result, VR[14]);
        check("R7", "b2b second exc", 32'(exc_out), 32'd1);
        @(negedge clk);
        check("R10", "b2b no extra done", 32'(done), 32'd0);

        // R11: result and flag hold while idle for many cycles
        repeat (10) @(negedge clk);
        check("R11", "idle hold result", result, VR[14]);
        check("R11", "idle hold exc", 32'(exc_out), 32'd1);

        // R11: reset clears a nonzero result
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R11", "re-reset result", result, 32'h0);
        check("R11", "re-reset exc", 32'(exc_out), 32'd0);
        rst = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule